// File: doc/BRIEF.md
# Touchscreen ADC Serial Responder

This block models the slave side of a touchscreen and housekeeping ADC that sits on a byte-serial bus. The host sends one byte per transfer and receives one byte back. A byte with its top bit set is a command. Bits 6:4 of a command pick one of eight analog channels. On the next transfer the responder captures that channel's 12-bit sample. It returns the result over two response bytes: the upper seven bits first, then the lower five bits left-aligned. After that it returns zeros until another command arrives.

The eight channel samples are stable parallel inputs. No conversion is modelled. The host's chip-select logic reports writes to its control setting through a strobe and a hold flag. A write made while hold was not active discards the latched command. A command can arrive on the same transfer that carries the second result byte. This gives the usual back-to-back conversion stream, one conversion for every two bytes.

Top module: `tsc_responder`

## Requirements
- R1: After reset `tx_byte` is 0x00 and no command is latched, so a transfer of 0x00 returns 0x00.
- R2: A transferred byte with bit 7 set is latched as the command and restarts the result sequence. The response returned on that same transfer comes from the state before the latch, which is 0x00 when no command was latched before.
- R3: Command bits 6:4 select the channel, where 0 is temp0, 1 is Y, 2 is battery, 3 is Z1, 4 is Z2, 5 is X, 6 is microphone and 7 is temp1. Channel n is `chan_samples[12n+11:12n]`.
- R4: The first transfer after a command captures the selected 12-bit sample and returns {1'b0, sample[11:5]}.
- R5: The next transfer returns {captured[4:0], 3'b000}. It uses the value captured in R4 even if the sample input has changed since.
- R6: Once both result bytes have been sent, every further transfer returns 0x00 until a new command arrives.
- R7: While no command is latched, transfers return 0x00.
- R8: A command sent on the transfer that returns the second result byte starts a new sequence. The following transfer returns the first result byte of the new channel.
- R9: A `cs_ctl_wr` strobe clears the latched command when the hold flag recorded by the previous strobe was 0, and keeps it when that flag was 1. The strobe then records `cs_hold_in`. The hold flag is 0 after reset.
- R10: `tx_byte` changes only on a cycle with `xfer_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_valid | input | 1 | One-cycle strobe: one byte exchanged |
| rx_byte | input | 8 | Byte written by the host in this transfer |
| cs_ctl_wr | input | 1 | Strobe: host wrote its chip-select control |
| cs_hold_in | input | 1 | Hold setting carried by that control write |
| chan_samples | input | 96 | Eight 12-bit channel samples, channel n at bits 12n+11:12n |
| tx_byte | output | 8 | Response byte of the most recent transfer |

## Verification
Every response is registered once, on the edge that sees `xfer_valid`. The bench raises the strobe on a falling edge and drops it on the next falling edge, and reads `tx_byte` on that same falling edge, one rising edge after the stimulus. A command's effect appears one transfer later than its own response. The bench therefore checks the command transfer against the earlier state and the next transfer against the new channel. Control-write effects are registered on the same edge as a strobe, so each is checked on the transfer that follows.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   // Sequence position inside one conversion readout
   typedef enum logic [1:0] {
      PH_START = 2'd0,   // next transfer captures and sends upper bits
      PH_LOW   = 2'd1,   // next transfer sends lower bits
      PH_DONE  = 2'd2    // result exhausted, zeros until a command
   } seq_phase_t;

   // Lowest bit of the channel field inside a command byte
   localparam int unsigned CHAN_LSB = 4;
endpackage

// File: rtl/tsc_cmd_latch.sv
module tsc_cmd_latch #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              cs_ctl_wr,
   input  logic              cs_hold_in,
   output logic [BYTE_W-1:0] ctrl_q,
   output logic              cmd_hit
);
   localparam int unsigned CMD_BIT = BYTE_W - 1;

   logic hold_q;

   assign cmd_hit = xfer_valid & rx_byte[CMD_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         hold_q <= 1'b0;
      end else begin
         if (cs_ctl_wr) begin
            if (!hold_q) ctrl_q <= '0;
            hold_q <= cs_hold_in;
         end
         // a command in the same cycle outranks a clear
         if (cmd_hit) ctrl_q <= rx_byte;
      end
   end
endmodule

// File: rtl/tsc_chan_mux.sv
module tsc_chan_mux #(
   parameter int unsigned SAMPLE_W = 12,
   parameter int unsigned SEL_W    = 3
) (
   input  logic [(2**SEL_W)*SAMPLE_W-1:0] chan_samples,
   input  logic [SEL_W-1:0]               sel,
   output logic [SAMPLE_W-1:0]            sample_out
);
   localparam int unsigned N_CHAN = 2 ** SEL_W;

   logic [SAMPLE_W-1:0] lanes [N_CHAN];

   for (genvar g = 0; g < N_CHAN; g++) begin : g_lane
      assign lanes[g] = chan_samples[g*SAMPLE_W +: SAMPLE_W];
   end

   assign sample_out = lanes[sel];
endmodule

// File: rtl/tsc_seq.sv
module tsc_seq
   import tsc_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 12,
   parameter int unsigned BYTE_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                xfer_valid,
   input  logic                cmd_hit,
   input  logic                ctrl_active,
   input  logic [SAMPLE_W-1:0] sample_in,
   output logic [BYTE_W-1:0]   tx_byte,
   output seq_phase_t          phase
);
   localparam int unsigned HI_W  = BYTE_W - 1;
   localparam int unsigned LO_W  = SAMPLE_W - HI_W;
   localparam int unsigned PAD_W = BYTE_W - LO_W;

   if (LO_W < 1 || LO_W > BYTE_W) begin : g_bad_split
      $error("tsc_seq: SAMPLE_W must lie in BYTE_W..2*BYTE_W-1");
   end

   logic [LO_W-1:0]   lo_q;
   logic [BYTE_W-1:0] hi_byte, lo_byte, resp_d;
   seq_phase_t        phase_d;
   logic              cap_en;

   assign hi_byte = {1'b0, sample_in[SAMPLE_W-1 -: HI_W]};

   if (PAD_W > 0) begin : g_lo_pad
      assign lo_byte = {lo_q, {PAD_W{1'b0}}};
   end else begin : g_lo_full
      assign lo_byte = lo_q;
   end

   always_comb begin
      resp_d  = '0;
      phase_d = phase;
      cap_en  = 1'b0;
      unique case (phase)
         PH_START: if (ctrl_active) begin
            resp_d  = hi_byte;
            phase_d = PH_LOW;
            cap_en  = 1'b1;
         end
         PH_LOW: begin
            resp_d  = lo_byte;
            phase_d = PH_DONE;
         end
         default: phase_d = PH_DONE;
      endcase
      if (cmd_hit) phase_d = PH_START;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_byte <= '0;
         phase   <= PH_START;
         lo_q    <= '0;
      end else if (xfer_valid) begin
         tx_byte <= resp_d;
         phase   <= phase_d;
         if (cap_en) lo_q <= sample_in[LO_W-1:0];
      end
   end
endmodule

// File: rtl/tsc_responder.sv
module tsc_responder
   import tsc_pkg::*;
#(
   parameter int unsigned SAMPLE_W   = 12,
   parameter int unsigned BYTE_W     = 8,
   parameter int unsigned CHAN_SEL_W = 3
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   xfer_valid,
   input  logic [BYTE_W-1:0]                      rx_byte,
   input  logic                                   cs_ctl_wr,
   input  logic                                   cs_hold_in,
   input  logic [(2**CHAN_SEL_W)*SAMPLE_W-1:0]    chan_samples,
   output logic [BYTE_W-1:0]                      tx_byte
);
   localparam int unsigned CMD_BIT = BYTE_W - 1;

   if (CHAN_LSB + CHAN_SEL_W > CMD_BIT) begin : g_bad_field
      $error("tsc_responder: channel field overlaps the command bit");
   end

   logic [BYTE_W-1:0]     ctrl_q;
   logic                  cmd_hit;
   logic [SAMPLE_W-1:0]   sample_sel;
   seq_phase_t            phase;

   tsc_cmd_latch #(.BYTE_W(BYTE_W)) u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .xfer_valid (xfer_valid),
      .rx_byte    (rx_byte),
      .cs_ctl_wr  (cs_ctl_wr),
      .cs_hold_in (cs_hold_in),
      .ctrl_q     (ctrl_q),
      .cmd_hit    (cmd_hit)
   );

   tsc_chan_mux #(.SAMPLE_W(SAMPLE_W), .SEL_W(CHAN_SEL_W)) u_mux (
      .chan_samples (chan_samples),
      .sel          (ctrl_q[CHAN_LSB +: CHAN_SEL_W]),
      .sample_out   (sample_sel)
   );

   tsc_seq #(.SAMPLE_W(SAMPLE_W), .BYTE_W(BYTE_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .xfer_valid  (xfer_valid),
      .cmd_hit     (cmd_hit),
      .ctrl_active (|ctrl_q),
      .sample_in   (sample_sel),
      .tx_byte     (tx_byte),
      .phase       (phase)
   );
endmodule

// File: rtl/tsc_responder_chk.sv
module tsc_responder_chk
   import tsc_pkg::*;
#(
   parameter int unsigned BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              xfer_valid,
   input logic [BYTE_W-1:0] rx_byte,
   input logic [BYTE_W-1:0] ctrl_q,
   input seq_phase_t        phase,
   input logic [BYTE_W-1:0] tx_byte
);
   // R2
   cmd_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && rx_byte[BYTE_W-1] |=> phase == PH_START && ctrl_q == $past(rx_byte));

   // R4
   hi_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && phase == PH_START && ctrl_q != '0 |=> !tx_byte[BYTE_W-1]);

   // R5
   lo_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && phase == PH_LOW |=> tx_byte[2:0] == 3'b000);

   // R6
   done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && phase == PH_DONE |=> tx_byte == '0);

   // R7
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && phase == PH_START && ctrl_q == '0 |=> tx_byte == '0);

   // R10
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_valid |=> $stable(tx_byte));
endmodule

bind tsc_responder tsc_responder_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .xfer_valid (xfer_valid),
   .rx_byte    (rx_byte),
   .ctrl_q     (ctrl_q),
   .phase      (phase),
   .tx_byte    (tx_byte)
);

// File: tb/tsc_responder_bench.sv
`timescale 1ns/1ps
module tsc_responder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xfer_valid = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        cs_ctl_wr = 1'b0;
   logic        cs_hold_in = 1'b0;
   logic [95:0] chan_samples = '0;
   logic [7:0]  tx_byte;
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   tsc_responder u_tsc_responder (
      .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .rx_byte(rx_byte),
      .cs_ctl_wr(cs_ctl_wr), .cs_hold_in(cs_hold_in),
      .chan_samples(chan_samples), .tx_byte(tx_byte)
   );

   function automatic logic [7:0] hi_of(input logic [11:0] s);
      return {1'b0, s[11:5]};
   endfunction
   function automatic logic [7:0] lo_of(input logic [11:0] s);
      return {s[4:0], 3'b000};
   endfunction

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
      end
   endtask

   task automatic set_sample(input int ch, input logic [11:0] v);
      chan_samples[ch*12 +: 12] = v;
   endtask

   // one byte exchange; returns the response registered for it
   task automatic xfer(input logic [7:0] b, output logic [7:0] resp);
      @(negedge clk);
      rx_byte = b; xfer_valid = 1'b1;
      @(negedge clk);
      xfer_valid = 1'b0; rx_byte = '0;
      resp = tx_byte;
   endtask

   task automatic ctl_write(input logic hold);
      @(negedge clk);
      cs_ctl_wr = 1'b1; cs_hold_in = hold;
      @(negedge clk);
      cs_ctl_wr = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] r;
      check("R1 reset tx", tx_byte, 8'h00);
      xfer(8'h00, r);
      check("R1/R7 no command after reset", r, 8'h00);
   endtask

   task automatic t_first_cmd();
      logic [7:0] r;
      xfer(8'h90, r);   // channel 1 (Y = 0xFFF)
      check("R2 command transfer returns prior state", r, 8'h00);
      xfer(8'h00, r);
      check("R4 Y upper byte", r, 8'h7F);
      xfer(8'h00, r);
      check("R5 Y lower byte", r, 8'hF8);
      xfer(8'h00, r);
      check("R6 zero after result", r, 8'h00);
      xfer(8'h12, r);
      check("R6 zero again, non-command byte", r, 8'h00);
   endtask

   task automatic t_channels();
      logic [7:0] r;
      for (int ch = 0; ch < 8; ch++)
         set_sample(ch, 12'((ch * 12'h2D7 + 12'h135) & 12'hFFF));
      for (int ch = 0; ch < 8; ch++) begin
         logic [11:0] v;
         v = 12'((ch * 12'h2D7 + 12'h135) & 12'hFFF);
         xfer(8'h80 | 8'(ch << 4), r);
         xfer(8'h00, r);
         check($sformatf("R3/R4 channel %0d upper", ch), r, hi_of(v));
         xfer(8'h00, r);
         check($sformatf("R3/R5 channel %0d lower", ch), r, lo_of(v));
      end
   endtask

   task automatic t_restart();
      logic [7:0] r;
      set_sample(2, 12'hABC);
      set_sample(6, 12'h5A3);
      xfer(8'hA0, r);
      xfer(8'h00, r);
      check("R8 first channel upper", r, hi_of(12'hABC));
      xfer(8'hE0, r);   // command rides on the lower-byte transfer
      check("R8 lower byte on command transfer", r, lo_of(12'hABC));
      xfer(8'h00, r);
      check("R8 new channel upper", r, hi_of(12'h5A3));
      xfer(8'h00, r);
      check("R8 new channel lower", r, lo_of(12'h5A3));
   endtask

   task automatic t_capture();
      logic [7:0] r;
      set_sample(4, 12'h3E7);
      xfer(8'hC0, r);
      xfer(8'h00, r);
      check("R4 Z2 upper", r, hi_of(12'h3E7));
      set_sample(4, 12'hC18);
      xfer(8'h00, r);
      check("R5 lower from captured value", r, lo_of(12'h3E7));
   endtask

   task automatic t_hold();
      logic [7:0] r;
      set_sample(2, 12'hABC);
      ctl_write(1'b1);              // hold becomes 1
      xfer(8'hA0, r);
      ctl_write(1'b0);              // hold was 1: command kept
      xfer(8'h00, r);
      check("R9 kept with hold", r, hi_of(12'hABC));
      xfer(8'hA0, r);
      ctl_write(1'b0);              // hold was 0: command cleared
      xfer(8'h00, r);
      check("R9 cleared without hold", r, 8'h00);
   endtask

   task automatic t_stable();
      logic [7:0] r;
      set_sample(1, 12'hFFF);
      xfer(8'h90, r);
      xfer(8'h00, r);
      repeat (5) @(negedge clk);
      check("R10 tx held while idle", tx_byte, 8'h7F);
      ctl_write(1'b0);
      check("R10 tx held across control write", tx_byte, 8'h7F);
   endtask

   initial begin
      set_sample(1, 12'hFFF);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_cmd();
      t_channels();
      t_restart();
      t_capture();
      t_hold();
      t_stable();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: got hung expected finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule